// File: doc/BRIEF.md
# Cascadable Serial Channel-Select Controller

This block is the digital control for a bank of eight analog switches that share one output node. A host sends a 4-bit command over a serial link made of three wires: a serial clock, a serial data input and an active-high select line. While select is high, each rising serial clock edge shifts one data bit into a 4-bit register. When select falls, the block turns off whichever switch is on. After a fixed all-off gap it turns on the switch that the captured command names, or none if the command is disabled.

The bit that leaves the far end of the shift register drives a serial data output. The next controller in a chain can take its data from there, so one host port with one select line programs N controllers by sending a 4N-bit stream. The serial output is enabled only while select is high.

All three serial inputs are asynchronous to the block's system clock. They pass through synchronizers of equal depth, and serial clock and select edges are detected in the system clock domain. The serial clock therefore has to run several times slower than the system clock.

Top module: `chsel_chain_ctrl`

## Requirements
- R1: While the synchronized select is high, each rising serial clock edge shifts `sdi_i` into the 4-bit command register. The previous contents move one place toward the output end.
- R2: The command is sent enable bit first, then the channel index from most significant to least significant bit. With enable 1, the index value k (0 to 7) turns on `sw_en_o[k]` alone, so index 000 gives bit 0 and index 111 gives bit 7.
- R3: A command whose enable bit is 0 leaves all eight switch enables at 0 after the gap, whatever its index bits hold.
- R4: `sw_en_o` is 0 from the third system clock edge after `sel_i` is first sampled low, and it is never nonzero in two bit patterns on consecutive cycles. At most one bit of `sw_en_o` is ever 1.
- R5: After a select fall, `sw_en_o` stays all zero for exactly `GAP_CYC` system clock cycles. It then shows the decoded command.
- R6: A channel that is on stays on while select is high and a new command is being shifted in. It changes only after the next select fall.
- R7: `sdo_o` is the most significant bit of the command register. The first bit of a stream appears there after the fourth rising serial clock edge, and bit j after edge 4+j.
- R8: `sdo_oe_o` follows `sel_i` through the two-stage synchronizer. It is 0 (output in high impedance) while select is low and 1 while select is high.
- R9: Rising serial clock edges while select is low leave the command register unchanged.
- R10: During and after reset, the command register is clear, `sw_en_o` is 0, `sdo_o` is 0 and `sdo_oe_o` is 0.
- R11: A select fall during the all-off gap drops the pending command. It restarts a full gap that uses the command register as it stands at the new fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sel_i | input | 1 | Active-high select, asynchronous |
| sdi_i | input | 1 | Serial command data input |
| sdo_o | output | 1 | Serial data output toward the next controller |
| sdo_oe_o | output | 1 | Output enable for `sdo_o`; 0 means high impedance |
| sw_en_o | output | 8 | One-hot switch enables, bit k drives channel k |

## Verification
The assertions check four properties on every cycle. They check that the switch enables are one-hot or zero and never jump straight from one channel to another. They check that every turn-on follows an all-zero run of at least `GAP_CYC` cycles. They also check that the output enable follows select through two stages and that the serial output moves only when the output enable was set. The bench's scenarios are needed to show the rest: that the decoded channel is the one the command names, and that a disabled command keeps everything off. Only the scenarios can also show that the serial output replays the stream delayed by four edges, that clock edges with select low are ignored, and that a second fall inside the gap replaces the pending command.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int IDX_W  = 3;
  localparam int NUM_CH = 1 << IDX_W;
  localparam int CMD_W  = IDX_W + 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  typedef enum logic {SEQ_HOLD = 1'b0, SEQ_GAP = 1'b1} seq_state_t;

  function automatic logic [NUM_CH-1:0] chsel_decode(input cmd_t c);
    logic [NUM_CH-1:0] dec;
    for (int i = 0; i < NUM_CH; i++) begin
      dec[i] = c.en && (c.idx == IDX_W'(i));
    end
    return dec;
  endfunction
endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/chsel_sync_bus.sv
module chsel_sync_bus #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_stg[s-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/chsel_shift_reg.sv
module chsel_shift_reg
  import chsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic sdi,
  output cmd_t cmd,
  output logic sdo
);
  logic [CMD_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[CMD_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign cmd = cmd_t'(sr_q);
  assign sdo = sr_q[CMD_W-1];
endmodule

// File: rtl/chsel_switch_seq.sv
module chsel_switch_seq
  import chsel_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  cmd_t              cmd,
  output logic [NUM_CH-1:0] sw_en
);
  localparam int CNT_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_t              pend_q, pend_d;
  logic [NUM_CH-1:0] sw_q, sw_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    sw_d   = sw_q;
    if (load) begin
      // break first: everything off, latest command becomes pending
      st_d   = SEQ_GAP;
      cnt_d  = GAP_LAST;
      pend_d = cmd;
      sw_d   = '0;
    end else if (st_q == SEQ_GAP) begin
      if (cnt_q == '0) begin
        sw_d = chsel_decode(pend_q);
        st_d = SEQ_HOLD;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_HOLD;
      cnt_q  <= '0;
      pend_q <= '0;
      sw_q   <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      sw_q   <= sw_d;
    end
  end

  assign sw_en = sw_q;
endmodule

// File: rtl/chsel_chain_ctrl.sv
module chsel_chain_ctrl
  import chsel_pkg::*;
#(
  parameter int GAP_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sel_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [NUM_CH-1:0] sw_en_o
);
  localparam int IN_W = 3;

  logic            rst_int_n;
  logic [IN_W-1:0] raw_in, sync_in;
  logic            sclk_s, sel_s, sdi_s;
  logic            sclk_q, sel_q;
  logic            sclk_rise, sel_fall, shift_en;
  cmd_t            cmd;

  chsel_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  assign raw_in = {sclk_i, sel_i, sdi_i};

  chsel_sync_bus #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (raw_in),
    .q    (sync_in)
  );

  assign {sclk_s, sel_s, sdi_s} = sync_in;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sel_fall  = sel_q & ~sel_s;
  assign shift_en  = sclk_rise & sel_s;

  chsel_shift_reg u_sr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_en(shift_en),
    .sdi     (sdi_s),
    .cmd     (cmd),
    .sdo     (sdo_o)
  );

  chsel_switch_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (sel_fall),
    .cmd  (cmd),
    .sw_en(sw_en_o)
  );

  assign sdo_oe_o = sel_s;
endmodule

// File: rtl/chsel_chain_ctrl_chk.sv
module chsel_chain_ctrl_chk #(
  parameter int GAP_CYC = 4,
  parameter int NUM_CH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [NUM_CH-1:0] sw_en_o
);
  localparam int ZW = $clog2(GAP_CYC + 1) + 1;

  logic [ZW-1:0] zrun;

  // length of the current run of all-zero switch enables, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    zrun <= '0;
    else if (|sw_en_o)             zrun <= '0;
    else if (zrun < ZW'(GAP_CYC))  zrun <= zrun + ZW'(1);
  end

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en_o));

  a_r4_break_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sw_en_o) && (|$past(sw_en_o))) |-> (sw_en_o == $past(sw_en_o)));

  a_r5_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sw_en_o) && !(|$past(sw_en_o))) |-> (zrun >= ZW'(GAP_CYC)));

  a_r8_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> $past(sel_i, 2));

  a_r8_oe_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe_o) |-> !$past(sel_i, 2));

  a_r7_sdo_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $past(sdo_oe_o));
endmodule

bind chsel_chain_ctrl chsel_chain_ctrl_chk #(
  .GAP_CYC(GAP_CYC),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel_i   (sel_i),
  .sdo_o   (sdo_o),
  .sdo_oe_o(sdo_oe_o),
  .sw_en_o (sw_en_o)
);

// File: tb/tb_chsel_chain_ctrl.sv
module tb_chsel_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 48;
  localparam int WD_LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sel = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe;
  logic [7:0] sw;

  int  nchk = 0, nerr = 0;
  bit  done = 1'b0;

  chsel_chain_ctrl #(.GAP_CYC(GAP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_i(sel), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sw_en_o(sw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: inputs seen by the design two edges late (history),
  // edges found from consecutive history entries
  logic [2:0] h_sel, h_sclk, h_sdi;   // [0] newest
  logic [3:0] m_reg;
  logic [7:0] m_sw;
  logic [3:0] m_pend;
  int         m_cnt;
  bit         m_busy, m_rise, m_fall;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_sel = '0; h_sclk = '0; h_sdi = '0;
      m_reg = '0; m_sw = '0; m_pend = '0; m_cnt = 0; m_busy = 0;
    end else begin
      m_rise = h_sclk[1] && !h_sclk[2];
      m_fall = !h_sel[1] && h_sel[2];
      if (m_rise && h_sel[1]) m_reg = {m_reg[2:0], h_sdi[1]};
      if (m_fall) begin
        m_sw = '0; m_cnt = GAP - 1; m_pend = m_reg; m_busy = 1;
      end else if (m_busy) begin
        if (m_cnt == 0) begin
          m_sw = m_pend[3] ? (8'd1 << m_pend[2:0]) : 8'd0;
          m_busy = 0;
        end else m_cnt--;
      end
      h_sel  = {h_sel[1:0], sel};
      h_sclk = {h_sclk[1:0], sclk};
      h_sdi  = {h_sdi[1:0], sdi};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R5 per-cycle switch enables", sw, m_sw);
      check("R7 per-cycle serial output", sdo, m_reg[3]);
      check("R8 per-cycle output enable", sdo_oe, h_sel[1]);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; tick(2);
    sclk = 1'b1; tick(3);
    sclk = 1'b0; tick(2);
  endtask

  task automatic load_cmd(input logic en, input logic [2:0] idx);
    sel = 1'b1; tick(3);
    shift_bit(en); shift_bit(idx[2]); shift_bit(idx[1]); shift_bit(idx[0]);
  endtask

  task automatic fall_settle(input logic [7:0] prev, input logic [7:0] nxt, input string tag);
    sel = 1'b0;
    tick(2);  check({tag, " R4 old channel held until fall seen"}, sw, prev);
    tick(1);  check({tag, " R4 all off on third edge"}, sw, 8'h00);
    tick(GAP - 1); check({tag, " R5 still off at last gap cycle"}, sw, 8'h00);
    tick(1);  check({tag, " R5 decoded channel after gap"}, sw, nxt);
  endtask

  initial begin
    tick(3);
    check("R10 reset switch enables", sw, 8'h00);
    check("R10 reset output enable", sdo_oe, 1'b0);
    check("R10 reset serial output", sdo, 1'b0);
    rst_n = 1'b1;
    tick(6);
    check("R10 idle after reset", sw, 8'h00);

    // R1 R2: enabled command, index 5
    load_cmd(1'b1, 3'd5);
    check("R8 output enable with select high", sdo_oe, 1'b1);
    fall_settle(8'h00, 8'h20, "R2 idx5");
    check("R8 output enable low after fall", sdo_oe, 1'b0);

    // R6: channel held while next command shifts; R2 low boundary
    load_cmd(1'b1, 3'd0);
    check("R6 channel held during shifting", sw, 8'h20);
    fall_settle(8'h20, 8'h01, "R2 idx0");

    // R2 high boundary
    load_cmd(1'b1, 3'd7);
    fall_settle(8'h01, 8'h80, "R2 idx7");

    // R3 disabled command with nonzero index
    load_cmd(1'b0, 3'd3);
    fall_settle(8'h80, 8'h00, "R3 disabled");

    // R7 chained stream: A = 1,010  then B = 1,110
    begin
      logic [7:0] stream;
      stream = 8'b1010_1110;
      sel = 1'b1; tick(3);
      for (int k = 0; k < 8; k++) begin
        sdi = stream[7-k]; tick(2);
        sclk = 1'b1; tick(3);
        if (k >= 3) check("R7 serial output replays stream", sdo, stream[7-(k-3)]);
        sclk = 1'b0; tick(2);
      end
      check("R1 register holds last four bits", sdo, 1'b1);
      fall_settle(8'h00, 8'h40, "R1 chain second command");
    end

    // R9: clock edges with select low are ignored
    sdi = 1'b0;
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    sel = 1'b1; tick(3);
    check("R9 register unchanged by edges while deselected", sdo, 1'b1);
    fall_settle(8'h40, 8'h40, "R9 same command reloads");

    // R11: second fall inside the gap replaces pending command
    load_cmd(1'b1, 3'd2);
    sel = 1'b0; tick(4);
    check("R11 off at start of first gap", sw, 8'h00);
    load_cmd(1'b1, 3'd6);
    check("R11 still off before second fall", sw, 8'h00);
    fall_settle(8'h00, 8'h40, "R11 restarted gap");

    tick(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected<%0d cycles", WD_LIMIT, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule